// File: doc/BRIEF.md
# GPIO Bank Controller

This block holds the control state for a bank of general-purpose pins and is reached over a single-cycle register bus. Software writes a pair of configuration words per pin to pick the pin's use (native function or general purpose), its direction, the level it drives, the trigger settings, whether its input is sensed, and its weak pull. The block turns these into pad controls: an output value, an output enable and a 2-bit pull code for every pin. It also samples every pad input through a synchronizer and shows the result in the pin's first configuration word.

Two bitmaps sit at the bottom of the map. The first has one bit per pin, spread over three 32-bit words, and a zero bit means the pin is held by firmware. The second is a 16-bit routing mask that covers only a fixed, irregular subset of the pins and marks those whose interrupt goes straight to an external interrupt controller. Both bitmaps are exported as per-pin vectors. For the routing mask, each pin's flag is looked up through the fixed map.

A read returns its data on `rdata` in the cycle after `rd_en` is sampled. The data comes from a registered stage, and `rdata` is zero in every cycle that does not follow a read.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin's first configuration word reads 0x00000005 (use select 1 = GPIO, direction 1 = input), every second configuration word reads 0x00000004 (sensing disabled, pull code 0), both bitmaps read zero, and `pad_oe`, `pad_pull`, `own_o` and `route_o` are all zero.
- R2: The first configuration word of pin p is at byte offset 0x100 + 8*p. Its writable fields are the output level (bit 31), trigger select (bit 4), invert (bit 3), direction (bit 2, 1 = input) and use select (bits 1:0). Bit 30 is the live input level and ignores writes. All other bits read zero.
- R3: The second configuration word of pin p is at 0x104 + 8*p. Bit 2 disables input sensing, and bits 1:0 are the pull code (0 none, 1 down, 2 up), driven on `pad_pull[2p+1:2p]`. All other bits read zero.
- R4: `pad_oe[p]` is 1 only while pin p has use select 1 and direction bit 0. `pad_out[p]` follows bit 31 of pin p's first word.
- R5: Bit 30 of pin p's first word shows `pad_in[p]` after a two-stage synchronizer. A change driven before a read's sampling edge shows up in the third back-to-back read. While sensing is disabled, bit 30 reads 0.
- R6: The firmware-ownership bitmap is at offsets 0x00, 0x04 and 0x08. Pin p is in word (p/32)*4, bit p%32, and bits above pin 94 read zero. `own_o[p]` carries pin p's bit.
- R7: The routing mask is at offset 0x10, and only its low 16 bits are stored. Pins 8-10 map to mask bits 0-2, pins 13-14 to bits 3-4 and pins 45-55 to bits 5-15. `route_o[p]` is the mapped bit for those pins and 0 for every other pin.
- R8: A write to an unmapped or misaligned offset (for example 0x0C, 0x3F8, 0x102) changes nothing, and a read from one returns zero.
- R9: `rdata` carries the addressed word in the cycle after `rd_en`, and it is zero in every cycle that does not follow a read.
- R10: A write to one pin's configuration word leaves every other pin's words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Byte address of the register |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after rd_en |
| pad_in | input | 95 | Pad input levels |
| pad_out | output | 95 | Pad output levels |
| pad_oe | output | 95 | Pad output enables |
| pad_pull | output | 190 | 2-bit pull code per pin |
| own_o | output | 95 | Ownership bitmap, one bit per pin |
| route_o | output | 95 | Direct-routing flag per pin |

## Verification
The assertions check four things on every cycle. A configuration write takes effect on the next cycle. The pull and sensing fields change only on writes to their own word. The sensed level equals the pad input from two cycles earlier whenever sensing is enabled. `rdata` is zero after idle cycles, after unmapped reads, and in the pad bits of the last ownership word. Other behaviour needs the bench's scenarios: the irregular routing map, the gating of the output enable by use select and direction, the isolation between pins, and the ignored writes to read-only or unmapped locations. These become visible only through chosen write and read sequences.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

   localparam int REG_W      = 32;
   localparam int CFG_BASE   = 'h100;
   localparam int ROUTE_OFS  = 'h10;
   localparam int ROUTE_BITS = 16;

   localparam logic [1:0] USE_GPIO = 2'd1;

   typedef struct packed {
      logic       lvl_out;
      logic       trig;
      logic       inv;
      logic       dir_in;
      logic [1:0] usel;
   } cfg1_t;

   typedef struct packed {
      logic       nosense;
      logic [1:0] pull;
   } cfg2_t;

   // Fixed map of pins onto the routing mask; -1 when a pin has no slot.
   function automatic int route_slot(int pin);
      if (pin >= 8 && pin <= 10)  return pin - 8;
      if (pin >= 13 && pin <= 14) return pin - 13 + 3;
      if (pin >= 45 && pin <= 55) return pin - 45 + 5;
      return -1;
   endfunction

endpackage

// File: rtl/gpb_bitmap.sv
module gpb_bitmap #(
   parameter int NBITS = 95,
   parameter int WIDTH = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NWORDS-1:0]         wr_word,
   input  logic [WIDTH-1:0]          wdata,
   output logic [NBITS-1:0]          bits,
   output logic [NWORDS*WIDTH-1:0]   rd_words
);
   localparam int NWORDS = (NBITS + WIDTH - 1) / WIDTH;
   localparam int TOT    = NWORDS * WIDTH;
   localparam logic [TOT:0]   ONE_SH = (TOT+1)'(1) << NBITS;
   localparam logic [TOT-1:0] VALID  = TOT'(ONE_SH - (TOT+1)'(1));

   if (NBITS < 1 || WIDTH < 1) begin : g_bad_cfg
      $error("gpb_bitmap: NBITS and WIDTH must be positive");
   end

   logic [TOT-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         for (int w = 0; w < NWORDS; w++) begin
            if (wr_word[w]) q[w*WIDTH +: WIDTH] <= wdata & VALID[w*WIDTH +: WIDTH];
         end
      end
   end

   assign bits     = q[NBITS-1:0];
   assign rd_words = q;

   // R6
   pad_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~VALID) == '0);

endmodule

// File: rtl/gpb_pin_cell.sv
module gpb_pin_cell
   import gpb_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             warm,
   input  logic             wr1,
   input  logic             wr2,
   input  cfg1_t            c1_in,
   input  cfg2_t            c2_in,
   input  logic             pad_in,
   output logic             pad_out,
   output logic             pad_oe,
   output logic [1:0]       pad_pull,
   output logic [REG_W-1:0] rd1,
   output logic [REG_W-1:0] rd2
);
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("gpb_pin_cell: SYNC_STAGES must be 2..4");
   end

   localparam cfg1_t C1_RST = '{lvl_out: 1'b0, trig: 1'b0, inv: 1'b0,
                                dir_in: 1'b1, usel: USE_GPIO};
   localparam cfg2_t C2_RST = '{nosense: 1'b1, pull: 2'd0};

   cfg1_t c1_q;
   cfg2_t c2_q;
   logic [SYNC_STAGES-1:0] sy;
   logic lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c1_q <= C1_RST;
         c2_q <= C2_RST;
      end else begin
         if (wr1) c1_q <= c1_in;
         if (wr2) c2_q <= c2_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= '0;
      else        sy <= {sy[SYNC_STAGES-2:0], pad_in};
   end

   assign lvl      = sy[SYNC_STAGES-1] & ~c2_q.nosense;
   assign pad_out  = c1_q.lvl_out;
   assign pad_oe   = (c1_q.usel == USE_GPIO) && !c1_q.dir_in;
   assign pad_pull = c2_q.pull;
   assign rd1      = {c1_q.lvl_out, lvl, 25'd0, c1_q.trig, c1_q.inv,
                      c1_q.dir_in, c1_q.usel};
   assign rd2      = {29'd0, c2_q};

   // R4
   out_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr1 |=> pad_out == $past(c1_in.lvl_out));

   // R3
   cfg2_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr2 |=> $stable(pad_pull) && $stable(rd2));

   // R5
   sensed_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !c2_q.nosense) |-> lvl == $past(pad_in, SYNC_STAGES));

   // R5
   sense_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr2 && c2_in.nosense) |-> !rd1[30]);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpb_pkg::*;
#(
   parameter int NPINS       = 95,
   parameter int AW          = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      addr,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wdata,
   output logic [REG_W-1:0]   rdata,
   input  logic [NPINS-1:0]   pad_in,
   output logic [NPINS-1:0]   pad_out,
   output logic [NPINS-1:0]   pad_oe,
   output logic [2*NPINS-1:0] pad_pull,
   output logic [NPINS-1:0]   own_o,
   output logic [NPINS-1:0]   route_o
);
   localparam int OWN_WORDS = (NPINS + REG_W - 1) / REG_W;
   localparam int CFG_END   = CFG_BASE + NPINS * 8;
   localparam int TAIL_BITS = NPINS % REG_W;

   if (NPINS < 56 || OWN_WORDS * 4 > ROUTE_OFS) begin : g_bad_pins
      $error("gpio_bank: NPINS must cover the routing map and fit below the routing mask");
   end
   if (CFG_END > (1 << AW)) begin : g_bad_aw
      $error("gpio_bank: AW too small for the per-pin registers");
   end

   // ---------------- decode ----------------
   logic          aligned, in_cfg, cfg_hi, in_own, in_route, mapped;
   logic [AW-1:0] cfg_word, own_word;

   always_comb begin
      aligned  = addr[1:0] == 2'b00;
      in_cfg   = aligned && int'(addr) >= CFG_BASE && int'(addr) < CFG_END;
      cfg_word = (addr - AW'(CFG_BASE)) >> 3;
      cfg_hi   = addr[2];
      in_own   = aligned && int'(addr) < OWN_WORDS * 4;
      own_word = addr >> 2;
      in_route = int'(addr) == ROUTE_OFS;
      mapped   = in_cfg || in_own || in_route;
   end

   // cycles since reset, saturating, for history-based checks
   logic [2:0] age;
   logic       warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    age <= '0;
      else if (int'(age) < SYNC_STAGES) age <= age + 3'd1;
   end
   assign warm = int'(age) >= SYNC_STAGES;

   cfg1_t c1_wr;
   cfg2_t c2_wr;
   assign c1_wr = '{lvl_out: wdata[31], trig: wdata[4], inv: wdata[3],
                    dir_in: wdata[2], usel: wdata[1:0]};
   assign c2_wr = '{nosense: wdata[2], pull: wdata[1:0]};

   // ---------------- per-pin cells ----------------
   logic [REG_W-1:0] rd1_arr [NPINS];
   logic [REG_W-1:0] rd2_arr [NPINS];

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic hit;
      assign hit = wr_en && in_cfg && (cfg_word == AW'(p));

      gpb_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .warm     (warm),
         .wr1      (hit && !cfg_hi),
         .wr2      (hit && cfg_hi),
         .c1_in    (c1_wr),
         .c2_in    (c2_wr),
         .pad_in   (pad_in[p]),
         .pad_out  (pad_out[p]),
         .pad_oe   (pad_oe[p]),
         .pad_pull (pad_pull[2*p +: 2]),
         .rd1      (rd1_arr[p]),
         .rd2      (rd2_arr[p])
      );
   end

   // ---------------- bitmaps ----------------
   logic [OWN_WORDS-1:0]       own_wr;
   logic [OWN_WORDS*REG_W-1:0] own_rd;
   logic [ROUTE_BITS-1:0]      route_bits;
   logic [REG_W-1:0]           route_rd;

   for (genvar w = 0; w < OWN_WORDS; w++) begin : g_own_wr
      assign own_wr[w] = wr_en && in_own && (own_word == AW'(w));
   end

   gpb_bitmap #(.NBITS(NPINS), .WIDTH(REG_W)) u_own (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_word  (own_wr),
      .wdata    (wdata),
      .bits     (own_o),
      .rd_words (own_rd)
   );

   gpb_bitmap #(.NBITS(ROUTE_BITS), .WIDTH(REG_W)) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_word  (wr_en && in_route),
      .wdata    (wdata),
      .bits     (route_bits),
      .rd_words (route_rd)
   );

   for (genvar p = 0; p < NPINS; p++) begin : g_route
      localparam int SL = route_slot(p);
      if (SL >= 0) begin : g_on
         assign route_o[p] = route_bits[SL];
      end else begin : g_off
         assign route_o[p] = 1'b0;
      end
   end

   // ---------------- read path ----------------
   logic [REG_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (in_cfg) begin
         for (int p = 0; p < NPINS; p++) begin
            if (cfg_word == AW'(p)) rd_mux = cfg_hi ? rd2_arr[p] : rd1_arr[p];
         end
      end else if (in_own) begin
         for (int w = 0; w < OWN_WORDS; w++) begin
            if (own_word == AW'(w)) rd_mux = own_rd[w*REG_W +: REG_W];
         end
      end else if (in_route) begin
         rd_mux = route_rd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
      else            rdata <= '0;
   end

   // R9
   idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && !$past(rd_en)) |-> rdata == '0);

   // R8
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && $past(rd_en && !mapped)) |-> rdata == '0);

   if (TAIL_BITS != 0) begin : g_tail_chk
      // R6
      tail_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (age != 0 && $past(rd_en && in_own && own_word == AW'(OWN_WORDS-1)))
            |-> (rdata >> TAIL_BITS) == '0);
   end

endmodule

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
   localparam int NP = 95;
   localparam int NV = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [11:0]     addr = '0;
   logic            rd_en = 1'b0;
   logic            wr_en = 1'b0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NP-1:0]   pad_in = '0;
   logic [NP-1:0]   pad_out, pad_oe, own_o, route_o;
   logic [2*NP-1:0] pad_pull;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   gpio_bank u_gpio_bank (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_pull(pad_pull), .own_o(own_o), .route_o(route_o)
   );

   // {is_write, requirement number, address, data, expected read value}
   localparam logic [84:0] VT [NV] = '{
      {1'b0, 8'd1,  12'h100, 32'h0,          32'h0000_0005},
      {1'b0, 8'd1,  12'h104, 32'h0,          32'h0000_0004},
      {1'b0, 8'd1,  12'h000, 32'h0,          32'h0000_0000},
      {1'b1, 8'd2,  12'h100, 32'hFFFF_FFFF,  32'h0},
      {1'b0, 8'd2,  12'h100, 32'h0,          32'h8000_001F},
      {1'b1, 8'd3,  12'h104, 32'hFFFF_FFFF,  32'h0},
      {1'b0, 8'd3,  12'h104, 32'h0,          32'h0000_0007},
      {1'b1, 8'd2,  12'h3F0, 32'h8000_0012,  32'h0},
      {1'b0, 8'd2,  12'h3F0, 32'h0,          32'h8000_0012},
      {1'b1, 8'd6,  12'h008, 32'hFFFF_FFFF,  32'h0},
      {1'b0, 8'd6,  12'h008, 32'h0,          32'h7FFF_FFFF},
      {1'b1, 8'd6,  12'h004, 32'h1234_5678,  32'h0},
      {1'b0, 8'd6,  12'h004, 32'h0,          32'h1234_5678},
      {1'b0, 8'd6,  12'h000, 32'h0,          32'h0000_0000},
      {1'b1, 8'd7,  12'h010, 32'hFFFF_FFFF,  32'h0},
      {1'b0, 8'd7,  12'h010, 32'h0,          32'h0000_FFFF},
      {1'b1, 8'd8,  12'h00C, 32'hFFFF_FFFF,  32'h0},
      {1'b0, 8'd8,  12'h00C, 32'h0,          32'h0000_0000},
      {1'b0, 8'd8,  12'h102, 32'h0,          32'h0000_0000},
      {1'b0, 8'd10, 12'h108, 32'h0,          32'h0000_0005}
   };

   task automatic check(input string req, input logic [191:0] got, input logic [191:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // all tasks are entered at a falling edge and return at one
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(req, 192'(rdata), 192'(exp));
   endtask

   function automatic logic [NP-1:0] route_exp(input logic [15:0] m);
      logic [NP-1:0] r = '0;
      for (int i = 0; i < 3; i++)  r[8 + i]  = m[i];
      for (int i = 0; i < 2; i++)  r[13 + i] = m[3 + i];
      for (int i = 0; i < 11; i++) r[45 + i] = m[5 + i];
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: pad-side reset state
      check("R1 pad_oe", 192'(pad_oe), 192'(0));
      check("R1 pad_pull", 192'(pad_pull), 192'(0));
      check("R1 own_o", 192'(own_o), 192'(0));
      check("R1 route_o", 192'(route_o), 192'(0));
      // R9: no read, rdata idle at zero
      check("R9 idle rdata", 192'(rdata), 192'(0));

      for (int i = 0; i < NV; i++) begin
         if (VT[i][84]) wr(VT[i][75:64], VT[i][63:32]);
         else rd($sformatf("R%0d vec%0d", VT[i][83:76], i), VT[i][75:64], VT[i][31:0]);
      end

      // R8: write to 0x3F8 (beyond last pin) must not alter anything
      wr(12'h3F8, 32'hFFFF_FFFF);
      rd("R8 beyond last pin", 12'h3F8, 32'h0);
      rd("R8 last pin intact", 12'h3F4, 32'h0000_0004);

      // R4: use select 3 blocks drive, GPIO+output enables it
      check("R4 oe blocked by native", 192'(pad_oe[0]), 192'(0));
      wr(12'h100, 32'h8000_0001);
      check("R4 oe on", 192'(pad_oe[0]), 192'(1));
      check("R4 out high", 192'(pad_out[0]), 192'(1));
      wr(12'h100, 32'h0000_0001);
      check("R4 out low", 192'(pad_out[0]), 192'(0));
      wr(12'h100, 32'h8000_0005);
      check("R4 oe off for input", 192'(pad_oe[0]), 192'(0));
      check("R10 neighbours not driven", 192'(pad_oe[NP-1:1]), 192'(0));

      // R3: pull code exported per pin
      wr(12'h12C, 32'h0000_0002);
      check("R3 pin5 pull up", 192'(pad_pull[11:10]), 192'(2));
      check("R3 pin0 pull kept", 192'(pad_pull[1:0]), 192'(3));

      // R6: ownership bits exported
      check("R6 own word1", 192'(own_o[63:32]), 192'(32'h1234_5678));
      check("R6 own word2", 192'(own_o[94:64]), 192'({31{1'b1}}));

      // R7: irregular routing map
      check("R7 route all", 192'(route_o), 192'(route_exp(16'hFFFF)));
      wr(12'h010, 32'h0000_0020);
      check("R7 route pin45", 192'(route_o), 192'(route_exp(16'h0020)));
      wr(12'h010, 32'h0000_8000);
      check("R7 route pin55", 192'(route_o), 192'(route_exp(16'h8000)));
      wr(12'h010, 32'h0000_0010);
      check("R7 route pin14", 192'(route_o), 192'(route_exp(16'h0010)));

      // R5: synchronizer latency on pin 3
      wr(12'h11C, 32'h0000_0000);
      pad_in[3] = 1'b1;
      rd("R5 sync stage1", 12'h118, 32'h0000_0005);
      rd("R5 sync stage2", 12'h118, 32'h0000_0005);
      rd("R5 sensed high", 12'h118, 32'h4000_0005);
      wr(12'h11C, 32'h0000_0004);
      rd("R5 sensing off", 12'h118, 32'h0000_0005);
      // R2: write to live-level bit ignored
      wr(12'h118, 32'h4000_0005);
      rd("R2 level bit read-only", 12'h118, 32'h0000_0005);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule